// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Trigger Bank

This block holds four programmable triggers and tests each one against every memory access and instruction fetch the hart performs. Every access comes with an operation kind (fetch/execute, load or store), the privilege level, an address and a data word. Each trigger selects whether it compares the address or the data. It then applies one of six compare modes: equality, unsigned at-or-above, unsigned below, an aligned power-of-two window, and two half-width masked compares. The trigger can be limited to particular operations and privilege levels.

Triggers are checked in index order and the lowest qualifying one wins. A trigger can be linked to the next one so that both must hit on the same access. While the hart sits in debug mode (nonzero debug cause), nothing is reported. The result is registered: one cycle after an access, `hit_valid`, the trigger index and that trigger's 4-bit action code appear at the outputs. Software programs triggers by writing a select register, then the control word and the compare value of the selected trigger.

Top module: `brk_trigger_bank`

## Requirements
- R1: One cycle after a cycle with `acc_valid` high, `hit_valid` shows whether any trigger reports, and `hit_index` gives the lowest reporting index. Without an access, `hit_valid` is low the next cycle.
- R2: When `dbg_cause` is nonzero during an access, `hit_valid` is low the next cycle.
- R3: Control bits [2:0] enable operations by `acc_op` code: bit 0 execute (code 0), bit 1 load (code 1), bit 2 store (code 2). A trigger whose bit for the current operation is clear never takes part.
- R4: Control bits [6:3] enable privilege levels by `acc_priv` code: bit 3 user (0), bit 4 supervisor (1), bit 5 hypervisor (2), bit 6 machine (3). A disabled level excludes the trigger.
- R5: Control bit 7 set compares `acc_data`; clear compares `acc_addr`.
- R6: With `acc_xlen32` high, the compared value is cut to its low 32 bits, and the half width used by the mask modes is 16.
- R7: Mode field bits [11:9]: 0 equal, 2 unsigned value >= compare, 3 unsigned value < compare.
- R8: Mode 1 (power-of-two window): let k be the number of consecutive one bits at the bottom of the compare value. The trigger matches when the value and the compare value agree above bit k-1. An all-ones compare value matches anything.
- R9: Mode 4: mask = compare value shifted right by half width; matches when (value & mask) == (compare & mask).
- R10: Mode 5: same mask; matches when ((value >> half width) & mask) == (compare & mask).
- R11: Control bit 8 (link) set: a matching trigger does not report by itself; a later unlinked matching trigger reports. A linked trigger that fails (not enabled or no match) suppresses the triggers that follow it, up to and including the first unlinked one; evaluation resumes after that.
- R12: `cfg_addr` 0 writes the select index from `cfg_wdata` low bits, 1 writes the control word (bits [15:0]) of the selected trigger, 2 writes its compare value. Reset clears all controls so no trigger fires. `hit_action` carries control bits [15:12] of the reported trigger.
- R13: Mode codes 6 and 7 never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 select, 1 control, 2 compare value |
| cfg_wdata | input | XLEN | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_op | input | 2 | 0 execute, 1 load, 2 store |
| acc_priv | input | 2 | 0 user, 1 supervisor, 2 hypervisor, 3 machine |
| acc_addr | input | XLEN | Access address |
| acc_data | input | XLEN | Access data |
| acc_xlen32 | input | 1 | Hart runs with 32-bit registers |
| dbg_cause | input | 3 | Nonzero while in debug mode |
| hit_valid | output | 1 | A trigger reported for the previous access |
| hit_index | output | 2 | Index of the reported trigger |
| hit_action | output | 4 | Action code of the reported trigger |

## Verification
Priority resolution and linking meet in the same evaluation. A linked pair and a lower- or higher-index standalone trigger can all match one access. The bench provokes this by programming trigger 0 linked to trigger 1 and trigger 2 standalone on the same data. It then checks that a full pair reports index 1, that a broken link hands the hit to index 2, and that a completed link with a failing partner reports nothing. Debug suppression also overlaps a plain hit. The same hitting access is replayed with a nonzero cause and must give no report.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [2:0] {
    MM_EQ    = 3'd0,
    MM_WIN   = 3'd1,
    MM_GE    = 3'd2,
    MM_LT    = 3'd3,
    MM_MLOW  = 3'd4,
    MM_MHIGH = 3'd5
  } match_mode_e;

  typedef struct packed {
    logic [3:0] action;
    logic [2:0] mode;
    logic       link;
    logic       use_data;
    logic [3:0] priv_en;
    logic [2:0] op_en;
  } trig_ctrl_t;

  localparam int CTRL_W = $bits(trig_ctrl_t);

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NTRIG = 4,
  localparam int IDX_W = $clog2(NTRIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [XLEN-1:0]  cfg_wdata,
  output trig_ctrl_t       ctrl_o  [NTRIG],
  output logic [XLEN-1:0]  tdata_o [NTRIG]
);

  logic [IDX_W-1:0] sel_q, sel_d;
  logic             sel_en;
  logic [NTRIG-1:0] ctrl_en, tdata_en;

  always_comb begin
    sel_en = cfg_we && (cfg_addr == 2'd0);
    sel_d  = cfg_wdata[IDX_W-1:0];
    for (int i = 0; i < NTRIG; i++) begin
      ctrl_en[i]  = cfg_we && (cfg_addr == 2'd1) && (sel_q == IDX_W'(i));
      tdata_en[i] = cfg_we && (cfg_addr == 2'd2) && (sel_q == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_slot
    trig_ctrl_t      ctrl_q;
    logic [XLEN-1:0] tdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
      end else if (ctrl_en[g]) begin
        ctrl_q <= trig_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tdata_q <= '0;
      end else if (tdata_en[g]) begin
        tdata_q <= cfg_wdata;
      end
    end

    assign ctrl_o[g]  = ctrl_q;
    assign tdata_o[g] = tdata_q;
  end

  // R12: a select write lands in the select register
  a_r12_select_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd0) |=> (sel_q == $past(cfg_wdata[IDX_W-1:0])));

endmodule

// File: rtl/trig_compare.sv
module trig_compare
  import trig_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2
) (
  input  trig_ctrl_t       ctrl_i,
  input  logic [XLEN-1:0]  tdata_i,
  input  logic [1:0]       op_i,
  input  logic [1:0]       priv_i,
  input  logic [XLEN-1:0]  addr_i,
  input  logic [XLEN-1:0]  data_i,
  input  logic             xlen32_i,
  output logic             qual_o,
  output logic             match_o
);

  localparam logic [XLEN-1:0] LOW32 = (XLEN'(1) << 32) - XLEN'(1);

  logic [XLEN-1:0] val, low_run, hmask, val_hi;
  logic            run;

  always_comb begin
    val = ctrl_i.use_data ? data_i : addr_i;
    if (xlen32_i) val = val & LOW32;

    run = 1'b1;
    for (int j = 0; j < XLEN; j++) begin
      run        = run & tdata_i[j];
      low_run[j] = run;
    end

    hmask  = xlen32_i ? (tdata_i >> 16) : (tdata_i >> HALF);
    val_hi = xlen32_i ? (val >> 16)     : (val >> HALF);

    case (ctrl_i.mode)
      MM_EQ:    match_o = (val == tdata_i);
      MM_WIN:   match_o = ((val & ~low_run) == (tdata_i & ~low_run));
      MM_GE:    match_o = (val >= tdata_i);
      MM_LT:    match_o = (val < tdata_i);
      MM_MLOW:  match_o = ((val & hmask) == (tdata_i & hmask));
      MM_MHIGH: match_o = ((val_hi & hmask) == (tdata_i & hmask));
      default:  match_o = 1'b0;
    endcase

    qual_o = (op_i != 2'd3) && ctrl_i.op_en[op_i] && ctrl_i.priv_en[priv_i];
  end

endmodule

// File: rtl/trig_arbiter.sv
module trig_arbiter #(
  parameter int NTRIG = 4,
  localparam int IDX_W = $clog2(NTRIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid_i,
  input  logic             halted_i,
  input  logic [NTRIG-1:0] qual_i,
  input  logic [NTRIG-1:0] match_i,
  input  logic [NTRIG-1:0] link_i,
  input  logic [3:0]       action_i [NTRIG],
  output logic             hit_valid_o,
  output logic [IDX_W-1:0] hit_index_o,
  output logic [3:0]       hit_action_o
);

  logic             chain_ok, done, found;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic [3:0]       act_d, act_q;
  logic             hv_d, hv_q;

  always_comb begin
    chain_ok = 1'b1;
    done     = 1'b0;
    found    = 1'b0;
    idx_d    = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (!done) begin
        if (!chain_ok) begin
          chain_ok = !link_i[i];
        end else if (qual_i[i] && match_i[i]) begin
          if (!link_i[i]) begin
            found = 1'b1;
            done  = 1'b1;
            idx_d = IDX_W'(i);
          end
        end else if (link_i[i]) begin
          chain_ok = 1'b0;
        end
      end
    end
    act_d = action_i[idx_d];
    hv_d  = acc_valid_i && found && !halted_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
    end else begin
      hv_q <= hv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= '0;
    end else if (acc_valid_i) begin
      idx_q <= idx_d;
      act_q <= act_d;
    end
  end

  assign hit_valid_o  = hv_q;
  assign hit_index_o  = idx_q;
  assign hit_action_o = act_q;

  // R1: no access, no report
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !hit_valid_o);
  // R2: debug mode suppresses every report
  a_r2_debug_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && halted_i) |=> !hit_valid_o);
  // R11: the reported trigger is never a linked one
  a_r11_report_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> (!hit_valid_o || !(($past(link_i) >> hit_index_o) & 1'b1)));
  // R1: the reported trigger was enabled and matched
  a_r1_report_matched: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> (!hit_valid_o ||
      ((($past(qual_i) & $past(match_i)) >> hit_index_o) & 1'b1) == 1'b1));

endmodule

// File: rtl/brk_trigger_bank.sv
module brk_trigger_bank
  import trig_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NTRIG = 4,
  localparam int IDX_W = $clog2(NTRIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [XLEN-1:0]  cfg_wdata,
  input  logic             acc_valid,
  input  logic [1:0]       acc_op,
  input  logic [1:0]       acc_priv,
  input  logic [XLEN-1:0]  acc_addr,
  input  logic [XLEN-1:0]  acc_data,
  input  logic             acc_xlen32,
  input  logic [2:0]       dbg_cause,
  output logic             hit_valid,
  output logic [IDX_W-1:0] hit_index,
  output logic [3:0]       hit_action
);

  trig_ctrl_t       ctrl  [NTRIG];
  logic [XLEN-1:0]  tdata [NTRIG];
  logic [NTRIG-1:0] qual, match, link;
  logic [3:0]       action [NTRIG];

  trig_cfg_regs #(.XLEN(XLEN), .NTRIG(NTRIG)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .ctrl_o   (ctrl),
    .tdata_o  (tdata)
  );

  for (genvar g = 0; g < NTRIG; g++) begin : g_cmp
    trig_compare #(.XLEN(XLEN)) i_cmp (
      .ctrl_i  (ctrl[g]),
      .tdata_i (tdata[g]),
      .op_i    (acc_op),
      .priv_i  (acc_priv),
      .addr_i  (acc_addr),
      .data_i  (acc_data),
      .xlen32_i(acc_xlen32),
      .qual_o  (qual[g]),
      .match_o (match[g])
    );
    assign link[g]   = ctrl[g].link;
    assign action[g] = ctrl[g].action;
  end

  trig_arbiter #(.NTRIG(NTRIG)) i_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid_i (acc_valid),
    .halted_i    (|dbg_cause),
    .qual_i      (qual),
    .match_i     (match),
    .link_i      (link),
    .action_i    (action),
    .hit_valid_o (hit_valid),
    .hit_index_o (hit_index),
    .hit_action_o(hit_action)
  );

endmodule

// File: tb/test_brk_trigger_bank.sv
module test_brk_trigger_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic        acc_valid;
  logic [1:0]  acc_op, acc_priv;
  logic [63:0] acc_addr, acc_data;
  logic        acc_xlen32;
  logic [2:0]  dbg_cause;
  logic        hit_valid;
  logic [1:0]  hit_index;
  logic [3:0]  hit_action;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  brk_trigger_bank i_brk_trigger_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_op(acc_op),
    .acc_priv(acc_priv), .acc_addr(acc_addr), .acc_data(acc_data),
    .acc_xlen32(acc_xlen32), .dbg_cause(dbg_cause), .hit_valid(hit_valid),
    .hit_index(hit_index), .hit_action(hit_action)
  );

  // control word: [15:12] action, [11:9] mode, [8] link, [7] data select,
  // [6:3] privilege enables {M,H,S,U}, [2:0] op enables {store,load,exec}
  function automatic logic [63:0] mk(logic [2:0] ops, logic [3:0] prv, logic sel,
                                     logic lnk, logic [2:0] md, logic [3:0] act);
    return {48'd0, act, md, lnk, sel, prv, ops};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [63:0] ctl, input logic [63:0] cmp);
    wr(2'd0, 64'(idx));
    wr(2'd1, ctl);
    wr(2'd2, cmp);
  endtask

  task automatic access(input logic [1:0] op, input logic [1:0] prv,
                        input logic [63:0] a, input logic [63:0] d,
                        input logic m32, input logic [2:0] dc);
    @(negedge clk);
    acc_valid = 1'b1; acc_op = op; acc_priv = prv;
    acc_addr = a; acc_data = d; acc_xlen32 = m32; dbg_cause = dc;
    @(negedge clk);
    acc_valid = 1'b0; dbg_cause = 3'd0;
  endtask

  task automatic chk(input string req, input logic ev, input logic [1:0] ei,
                     input logic [3:0] ea);
    checks++;
    if (hit_valid !== ev || (ev && (hit_index !== ei || hit_action !== ea))) begin
      failures++;
      $display("FAIL %s actual valid=%0b idx=%0d act=%0d expected valid=%0b idx=%0d act=%0d",
               req, hit_valid, hit_index, hit_action, ev, ei, ea);
    end
  endtask

  localparam int NV = 9;
  localparam logic [1:0]  V_OP   [NV] = '{0, 0, 0, 1, 1, 2, 0, 2, 0};
  localparam logic [1:0]  V_PRV  [NV] = '{3, 0, 3, 1, 1, 0, 3, 3, 2};
  localparam logic [63:0] V_ADDR [NV] = '{64'h1000, 64'h1000, 64'h3000, 64'h40AB, 64'h0,
                                          64'h4100, 64'h1FFF, 64'h40FF, 64'h4000};
  localparam logic [63:0] V_DATA [NV] = '{64'h0, 64'h0, 64'h0, 64'h50, 64'h100,
                                          64'hFF, 64'h0, '1, 64'h0};
  localparam logic        E_HIT  [NV] = '{1, 1, 0, 1, 1, 0, 1, 1, 1};
  localparam logic [1:0]  E_IDX  [NV] = '{0, 2, 0, 3, 1, 0, 2, 1, 3};
  localparam logic [3:0]  E_ACT  [NV] = '{1, 3, 0, 4, 2, 0, 3, 2, 4};

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; acc_valid = 0;
    acc_op = 0; acc_priv = 0; acc_addr = 0; acc_data = 0; acc_xlen32 = 0; dbg_cause = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: after reset no trigger is enabled
    chk("R12 reset", 0, 0, 0);
    access(0, 3, 64'h0, 64'h0, 0, 0);
    chk("R12 reset-cleared triggers", 0, 0, 0);

    // table set-up: R3 R4 R5 R7 R8
    prog(0, mk(3'b001, 4'b1000, 0, 0, 3'd0, 4'd1), 64'h1000);
    prog(1, mk(3'b110, 4'b1111, 1, 0, 3'd2, 4'd2), 64'h100);
    prog(2, mk(3'b001, 4'b1111, 0, 0, 3'd3, 4'd3), 64'h2000);
    prog(3, mk(3'b111, 4'b1111, 0, 0, 3'd1, 4'd4), 64'h40FF);
    for (int v = 0; v < NV; v++) begin
      access(V_OP[v], V_PRV[v], V_ADDR[v], V_DATA[v], 0, 0);
      chk($sformatf("R1/R3/R4/R5/R7/R8 vector %0d", v), E_HIT[v], E_IDX[v], E_ACT[v]);
    end
    @(negedge clk);
    chk("R1 idle after access", 0, 0, 0);

    // R2: debug mode suppresses a hit that vector 0 would give
    access(0, 3, 64'h1000, 64'h0, 0, 3'd2);
    chk("R2 debug cause", 0, 0, 0);

    // clear everything for directed tests
    for (int t = 0; t < 4; t++) prog(t, 64'h0, 64'h0);

    // R6: 32-bit truncation
    prog(0, mk(3'b001, 4'b1111, 0, 0, 3'd0, 4'd5), 64'h1000);
    access(0, 0, 64'hFFFF_FFFF_0000_1000, 0, 1, 0);
    chk("R6 truncated match", 1, 0, 5);
    access(0, 0, 64'hFFFF_FFFF_0000_1000, 0, 0, 0);
    chk("R6 full width miss", 0, 0, 0);

    // R7: less-than boundary
    prog(0, mk(3'b001, 4'b1111, 0, 0, 3'd3, 4'd6), 64'h10);
    access(0, 0, 64'h10, 0, 0, 0);
    chk("R7 lt equal miss", 0, 0, 0);
    access(0, 0, 64'hF, 0, 0, 0);
    chk("R7 lt below hit", 1, 0, 6);

    // R8: all-ones window matches anything
    prog(0, mk(3'b001, 4'b1111, 0, 0, 3'd1, 4'd7), '1);
    access(0, 0, 64'hDEAD_BEEF_1234_5678, 0, 0, 0);
    chk("R8 all-ones window", 1, 0, 7);

    // R9: mask low, mask 0xFF00 (half width 32)
    prog(0, mk(3'b001, 4'b1111, 0, 0, 3'd4, 4'd8), 64'h0000_FF00_0000_1200);
    access(0, 0, 64'hAB12_34CD, 0, 0, 0);
    chk("R9 mask low miss", 0, 0, 0);
    access(0, 0, 64'h12FF, 0, 0, 0);
    chk("R9 mask low hit", 1, 0, 8);

    // R10: mask high with same mask
    prog(0, mk(3'b001, 4'b1111, 0, 0, 3'd5, 4'd9), 64'h0000_FF00_0000_1200);
    access(0, 0, 64'h0000_12AB_0000_0000, 0, 0, 0);
    chk("R10 mask high hit", 1, 0, 9);
    access(0, 0, 64'h12AB, 0, 0, 0);
    chk("R10 mask high miss", 0, 0, 0);

    // R13: reserved mode never matches
    prog(0, mk(3'b001, 4'b1111, 0, 0, 3'd6, 4'd1), 64'h0);
    access(0, 0, 64'h0, 0, 0, 0);
    chk("R13 mode 6", 0, 0, 0);
    prog(0, mk(3'b001, 4'b1111, 0, 0, 3'd7, 4'd1), 64'h0);
    access(0, 0, 64'h0, 0, 0, 0);
    chk("R13 mode 7", 0, 0, 0);

    // R11: trigger 0 linked to trigger 1, trigger 2 standalone
    prog(0, mk(3'b001, 4'b1111, 0, 1, 3'd0, 4'd10), 64'h500);
    prog(1, mk(3'b001, 4'b1111, 1, 0, 3'd0, 4'd11), 64'h77);
    prog(2, mk(3'b001, 4'b1111, 1, 0, 3'd0, 4'd12), 64'h77);
    access(0, 0, 64'h500, 64'h77, 0, 0);
    chk("R11 full pair reports partner", 1, 1, 11);
    access(0, 0, 64'h501, 64'h77, 0, 0);
    chk("R11 broken link passes to next", 1, 2, 12);
    access(0, 0, 64'h500, 64'h78, 0, 0);
    chk("R11 linked alone silent", 0, 0, 0);

    // R12: writes only touch the selected slot
    prog(3, mk(3'b010, 4'b1111, 0, 0, 3'd0, 4'd13), 64'h900);
    access(1, 0, 64'h900, 0, 0, 0);
    chk("R12 selected slot 3", 1, 3, 13);
    access(0, 0, 64'h900, 0, 0, 0);
    chk("R3 op disabled", 0, 0, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule